// File: doc/BRIEF.md
# Slave Serial Bitstream Loader

This block pushes a configuration image into a programmable target device over a slave-serial link. A start pulse makes it pull the target's active-low program line low for a fixed time and then release it. It then waits for the target's active-low init line to read high. After that it takes image bytes from a valid/ready byte stream and shifts each one onto a single data pin. For every bit it makes one configuration clock pulse.

The number of bytes in the image is given on an input and is captured when the start pulse is accepted. When that count is used up, the block sends a run of dummy clock pulses with the data pin held high. It then waits for the target's done line. The block flags an image error if init drops while bits are moving. It flags a timeout if init or done fails to rise in time. While the block is busy, a slow byte source only stretches the low time of the configuration clock.

The init and done inputs pass through a synchronizer before the controller uses them. The program-low width, the clock half period, the number of dummy pulses and the timeout limit are all parameters counted in system clock cycles. PROG_LOW_CYC must be larger than SYNC_STAGES.

Top module: `bitload_ctrl`

## Requirements
- R1: A start pulse is taken only when busy is low, that is in the idle, success or error resting state. A taken start drives tgt_prog_n low for exactly PROG_LOW_CYC cycles and then high. A start pulse while busy has no effect.
- R2: After tgt_prog_n is released, no configuration clock pulse is made and in_ready stays low until the synchronized tgt_init_n reads high. If it stays low for TIMEOUT_CYC cycles, err_timeout is set and busy drops, so that busy was high for PROG_LOW_CYC + TIMEOUT_CYC cycles.
- R3: Each byte is sent most-significant bit first: bit 7 goes out on the first clock pulse of the byte and bit 0 on the eighth.
- R4: The data bit is placed on tgt_din while tgt_cclk is low, and it does not change while tgt_cclk is high. Each high phase lasts exactly HALF_CYC cycles, and each low phase lasts at least HALF_CYC cycles.
- R5: in_ready is high only while loading, with no bit in flight and bytes still owed. A byte is taken when in_valid and in_ready are both high. While no byte is offered, tgt_cclk stays low and in_ready stays high.
- R6: Exactly byte_count bytes are taken per run, and further offered bytes are refused. A count of zero takes no bytes and goes straight to the dummy pulses.
- R7: After the last byte, exactly TRAIL_CLKS dummy clock pulses are issued with tgt_din held at 1.
- R8: If the synchronized tgt_init_n reads low while data or dummy bits are being sent, err_crc is set. tgt_cclk returns low, in_ready drops and no further clock pulse follows. When this collides with the completion of the last byte, the error wins and no dummy pulse is sent.
- R9: If tgt_done rises after the dummy pulses, ok is set. If done stays low for TIMEOUT_CYC cycles, err_timeout is set instead.
- R10: busy is high in every state other than the three resting states. ok is never high together with an error flag or with busy. Both error flags are cleared by a taken start pulse. After reset, busy, ok and both error flags are low, tgt_prog_n is high and tgt_cclk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| byte_count | input | CNT_W | Image length in bytes, captured at start |
| in_data | input | 8 | Image byte from the source |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Loader takes the byte this cycle if valid |
| tgt_prog_n | output | 1 | Active-low program strobe to the target |
| tgt_init_n | input | 1 | Active-low init/error line from the target |
| tgt_done | input | 1 | Configuration-complete line from the target |
| tgt_cclk | output | 1 | Configuration clock to the target |
| tgt_din | output | 1 | Serial data to the target |
| busy | output | 1 | A load sequence is in progress |
| ok | output | 1 | Last load finished with done high |
| err_crc | output | 1 | Init dropped during the bit transfer |
| err_timeout | output | 1 | Init or done failed to rise in time |

## Verification
Two events can land in the same cycle: the shifter finishing the final data bit, and the synchronized init line reporting an image error. The bench provokes this by having its target model pull init low on the rising edge of the very last data bit. With two synchronizer stages, the error then arrives exactly when the loader would move on to the dummy pulses. The bench judges the outcome at the pins: err_crc must be set, ok must stay low and no dummy pulse may appear. A second overlap, a start pulse arriving in the middle of a load, is judged by counting program pulses and confirming that the load still completes.

// File: rtl/bitload_pkg.sv
package bitload_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_LOW,
    ST_WAIT_INIT,
    ST_SHIFT,
    ST_TRAIL,
    ST_CHECK_DONE,
    ST_OK,
    ST_ERR
  } ld_state_e;

  // larger of two counts, used to size shared counters
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // states in which a new start is honoured and busy is low
  function automatic logic is_rest(input ld_state_e s);
    return (s == ST_IDLE) || (s == ST_OK) || (s == ST_ERR);
  endfunction

endpackage

// File: rtl/bitload_sync.sv
module bitload_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bitload_timer.sv
module bitload_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bitload_shifter.sv
module bitload_shifter #(
  parameter int HALF_CYC = 4,
  parameter int BCW      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [7:0]     load_data,
  input  logic [BCW-1:0] load_bits,
  input  logic           abort,
  output logic           din,
  output logic           cclk,
  output logic           empty
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

  logic [7:0]     sh;
  logic [BCW-1:0] left;
  logic [PW-1:0]  ph;
  logic           hi;

  assign empty = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= 8'hFF;
      left <= '0;
      ph   <= '0;
      hi   <= 1'b0;
    end else if (abort) begin
      left <= '0;
      ph   <= '0;
      hi   <= 1'b0;
    end else if (load && empty) begin
      sh   <= load_data;
      left <= load_bits;
      ph   <= '0;
      hi   <= 1'b0;
    end else if (!empty) begin
      if (ph == PH_LAST) begin
        ph <= '0;
        if (!hi) begin
          hi <= 1'b1;
        end else begin
          // falling edge: next bit appears, vacated slot fills with 1
          hi   <= 1'b0;
          sh   <= {sh[6:0], 1'b1};
          left <= left - 1'b1;
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign din  = sh[7];
  assign cclk = hi;
endmodule

// File: rtl/bitload_ctrl.sv
module bitload_ctrl
  import bitload_pkg::*;
#(
  parameter int PROG_LOW_CYC = 64,
  parameter int HALF_CYC     = 4,
  parameter int TRAIL_CLKS   = 10,
  parameter int TIMEOUT_CYC  = 1000000,
  parameter int CNT_W        = 24,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             tgt_prog_n,
  input  logic             tgt_init_n,
  input  logic             tgt_done,
  output logic             tgt_cclk,
  output logic             tgt_din,
  output logic             busy,
  output logic             ok,
  output logic             err_crc,
  output logic             err_timeout
);
  localparam int TW  = cnt_bits(max2(TIMEOUT_CYC, PROG_LOW_CYC));
  localparam int BCW = cnt_bits(max2(8, TRAIL_CLKS));
  localparam logic [TW-1:0] PROG_LAST = TW'(PROG_LOW_CYC - 1);
  localparam logic [TW-1:0] TO_LAST   = TW'(TIMEOUT_CYC - 1);

  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] left_q;
  logic             err_crc_q, err_to_q, prog_n_q;
  logic             init_s, done_s;
  logic [TW-1:0]    tmr;
  logic             sh_empty, sh_load, sh_abort;
  logic [7:0]       sh_data;
  logic [BCW-1:0]   sh_bits;

  // named internal events, also observed by the checker
  logic ev_start, ev_take, ev_crc, ev_timeout;

  bitload_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_init (
    .clk(clk), .rst_n(rst_n), .d(tgt_init_n), .q(init_s));
  bitload_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d(tgt_done), .q(done_s));

  bitload_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .cnt(tmr));

  assign in_ready   = (state_q == ST_SHIFT) && sh_empty && (left_q != '0) && init_s;
  assign ev_start   = start && is_rest(state_q);
  assign ev_take    = in_valid && in_ready;
  assign ev_crc     = ((state_q == ST_SHIFT) || (state_q == ST_TRAIL)) && !init_s;
  assign ev_timeout = (((state_q == ST_WAIT_INIT) && !init_s) ||
                       ((state_q == ST_CHECK_DONE) && !done_s)) && (tmr == TO_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_ERR: if (start) state_d = ST_PROG_LOW;
      ST_PROG_LOW:   if (tmr == PROG_LAST) state_d = ST_WAIT_INIT;
      ST_WAIT_INIT:  if (init_s) state_d = ST_SHIFT;
                     else if (ev_timeout) state_d = ST_ERR;
      // init error outranks the move to the dummy pulses
      ST_SHIFT:      if (ev_crc) state_d = ST_ERR;
                     else if ((left_q == '0) && sh_empty) state_d = ST_TRAIL;
      ST_TRAIL:      if (ev_crc) state_d = ST_ERR;
                     else if (sh_empty && (tmr != '0)) state_d = ST_CHECK_DONE;
      ST_CHECK_DONE: if (done_s) state_d = ST_OK;
                     else if (ev_timeout) state_d = ST_ERR;
      default:       state_d = ST_IDLE;
    endcase
  end

  // dummy pulses reuse the shifter: all-ones data and one-fill keep din high
  assign sh_load  = ev_take || ((state_q == ST_TRAIL) && (tmr == '0));
  assign sh_data  = (state_q == ST_TRAIL) ? 8'hFF : in_data;
  assign sh_bits  = (state_q == ST_TRAIL) ? BCW'(TRAIL_CLKS) : BCW'(8);
  assign sh_abort = ev_crc;

  bitload_shifter #(.HALF_CYC(HALF_CYC), .BCW(BCW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(sh_data),
    .load_bits(sh_bits), .abort(sh_abort), .din(tgt_din),
    .cclk(tgt_cclk), .empty(sh_empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      err_crc_q <= 1'b0;
      err_to_q  <= 1'b0;
      prog_n_q  <= 1'b1;
    end else begin
      state_q  <= state_d;
      prog_n_q <= (state_d != ST_PROG_LOW);
      if (ev_start) begin
        left_q    <= byte_count;
        err_crc_q <= 1'b0;
        err_to_q  <= 1'b0;
      end else begin
        if (ev_take)    left_q    <= left_q - CNT_W'(1);
        if (ev_crc)     err_crc_q <= 1'b1;
        if (ev_timeout) err_to_q  <= 1'b1;
      end
    end
  end

  assign tgt_prog_n  = prog_n_q;
  assign busy        = !is_rest(state_q);
  assign ok          = (state_q == ST_OK);
  assign err_crc     = err_crc_q;
  assign err_timeout = err_to_q;
endmodule

// File: rtl/bitload_chk.sv
module bitload_chk
  import bitload_pkg::*;
#(
  parameter int PROG_LOW_CYC = 64
) (
  input logic      clk,
  input logic      rst_n,
  input logic      in_ready,
  input logic      tgt_prog_n,
  input logic      tgt_cclk,
  input logic      tgt_din,
  input logic      busy,
  input logic      ok,
  input logic      err_crc,
  input logic      err_timeout,
  input ld_state_e state,
  input logic      ev_take,
  input logic      ev_crc
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (!tgt_prog_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= '0;
  end

  p_prog_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_prog_n) |-> (low_cnt == PROG_LOW_CYC));

  p_prog_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_prog_n |-> (low_cnt < PROG_LOW_CYC));

  p_prog_from_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_prog_n) |-> $past(!busy));

  p_quiet_in_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_prog_n |-> (!tgt_cclk && !in_ready));

  p_din_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_cclk |-> $stable(tgt_din));

  p_ready_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tgt_cclk);

  p_take_in_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |-> (state == ST_SHIFT));

  p_trail_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_TRAIL) && tgt_cclk) |-> tgt_din);

  p_crc_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc |=> (!tgt_cclk && err_crc && !in_ready && !busy));

  p_ok_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (!err_crc && !err_timeout && !busy));

endmodule

bind bitload_ctrl bitload_chk #(.PROG_LOW_CYC(PROG_LOW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tgt_prog_n(tgt_prog_n),
  .tgt_cclk(tgt_cclk), .tgt_din(tgt_din), .busy(busy), .ok(ok),
  .err_crc(err_crc), .err_timeout(err_timeout), .state(state_q),
  .ev_take(ev_take), .ev_crc(ev_crc));

// File: tb/bitload_ctrl_bench.sv
module bitload_ctrl_bench;
  localparam int PROG_LOW_CYC = 5;
  localparam int HALF_CYC     = 2;
  localparam int TRAIL_CLKS   = 10;
  localparam int TIMEOUT_CYC  = 300;
  localparam int CNT_W        = 16;
  localparam int SYNC_STAGES  = 2;
  localparam int INIT_DLY     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, tgt_prog_n, tgt_cclk, tgt_din, busy, ok, err_crc, err_timeout;
  logic tgt_init_n = 1'b0;
  logic tgt_done = 1'b0;

  always #5 clk = ~clk;

  bitload_ctrl #(
    .PROG_LOW_CYC(PROG_LOW_CYC), .HALF_CYC(HALF_CYC), .TRAIL_CLKS(TRAIL_CLKS),
    .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_bitload_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tgt_prog_n(tgt_prog_n), .tgt_init_n(tgt_init_n), .tgt_done(tgt_done),
    .tgt_cclk(tgt_cclk), .tgt_din(tgt_din), .busy(busy), .ok(ok),
    .err_crc(err_crc), .err_timeout(err_timeout));

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard and target-model state
  logic [7:0] exp_q[$];
  int  accepted = 0;
  int  data_bits = 0;
  bit  init_stuck = 0;
  bit  done_en = 1;
  int  fail_bit = 0;
  bit  failed = 0;
  int  rx_bits = 0, trail_cnt = 0, trail_bad = 0;
  int  hi_bad = 0, low_bad = 0, din_bad = 0, early = 0;
  int  prog_run = 0, last_prog_w = 0, prog_pulses = 0;
  int  init_cnt = 0, done_cnt = 0, hi_run = 0, low_run = 0;
  bit  waiting = 0, cclk_prev = 0, din_rise = 0;
  logic [7:0] rx_sh = '0;

  // behavioural target and monitor, all work on the falling clock edge
  always @(negedge clk) begin
    logic [7:0] e;
    if (!rst_n) begin
      tgt_init_n = 1'b0;
      tgt_done   = 1'b0;
      cclk_prev  = 1'b0;
    end else begin
      if (!tgt_prog_n) begin
        prog_run++;
        tgt_init_n = 1'b0; tgt_done = 1'b0;
        init_cnt = INIT_DLY; failed = 0; waiting = 1;
        rx_bits = 0; trail_cnt = 0; trail_bad = 0;
        hi_bad = 0; low_bad = 0; din_bad = 0; early = 0;
        done_cnt = 0; low_run = 100; hi_run = 0;
      end else begin
        if (prog_run != 0) begin
          last_prog_w = prog_run; prog_pulses++; prog_run = 0;
        end
        if (init_cnt > 0) init_cnt--;
        else if (!init_stuck && !failed) begin
          tgt_init_n = 1'b1; waiting = 0;
        end
      end
      if (waiting && in_ready) early++;
      if (tgt_cclk && !cclk_prev) begin
        if (waiting) early++;
        if (low_run < HALF_CYC) low_bad++;
        rx_bits++; din_rise = tgt_din; hi_run = 0;
        if (rx_bits <= data_bits) begin
          rx_sh = {rx_sh[6:0], tgt_din};
          if (rx_bits % 8 == 0) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 byte arrived with none expected", int'(rx_sh), -1);
            else begin
              e = exp_q.pop_front();
              chk(rx_sh == e, "R3 msb-first byte at target", int'(rx_sh), int'(e));
            end
          end
        end else begin
          trail_cnt++;
          if (!tgt_din) trail_bad++;
        end
        if (fail_bit != 0 && rx_bits == fail_bit) begin
          failed = 1; tgt_init_n = 1'b0;
        end
      end
      if (tgt_cclk) begin
        hi_run++;
        if (tgt_din != din_rise) din_bad++;
      end else begin
        if (cclk_prev) begin
          if (hi_run != HALF_CYC) hi_bad++;
          low_run = 0;
        end
        low_run++;
      end
      if (done_en && !failed && tgt_prog_n && rx_bits == data_bits + TRAIL_CLKS) begin
        if (done_cnt < 3) done_cnt++;
        else tgt_done = 1'b1;
      end
      cclk_prev = tgt_cclk;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    if (seed == 0) begin
      case (i)
        0: return 8'h01;
        1: return 8'h80;
        2: return 8'hA5;
        default: return 8'h3C;
      endcase
    end
    return 8'((i + 1) * 37 + seed * 11);
  endfunction

  // driver: offers bytes, pushes each accepted one to the scoreboard
  task automatic feed(input int n, input int gap, input int seed);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < gap; k++) begin
        @(negedge clk);
        if (i > 0 && gap >= 50 && k == 45)
          chk(!tgt_cclk && in_ready, "R5 stalled source keeps clock low and ready high",
              {tgt_cclk, in_ready}, 1);
      end
      in_data = pat(seed, i); in_valid = 1'b1;
      while (!in_ready && busy) @(negedge clk);
      if (in_ready) begin
        exp_q.push_back(in_data); accepted++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      if (!busy) break;
    end
  endtask

  task automatic wait_idle(input int lim);
    int n = 0;
    while (busy && n < lim) begin @(negedge clk); n++; end
    chk(!busy, "R10 load sequence ends", n, lim);
  endtask

  task automatic run_prep(input int cnt);
    exp_q.delete(); accepted = 0; data_bits = cnt * 8;
    byte_count = CNT_W'(cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ok && !err_crc && !err_timeout, "R10 reset flags low",
        {busy, ok, err_crc, err_timeout}, 0);
    chk(tgt_prog_n && !tgt_cclk && !in_ready, "R10 reset pins idle",
        {tgt_prog_n, tgt_cclk, in_ready}, 4);

    // normal load, one extra byte offered, start pulse mid-load
    run_prep(4); prog_pulses = 0;
    pulse_start();
    chk(busy, "R10 busy after start", busy, 1);
    fork
      feed(5, 3, 0);
      begin repeat (60) @(negedge clk); pulse_start(); end
    join_any
    wait_idle(2000);
    wait fork;
    chk(ok && !err_crc && !err_timeout, "R9 done raises ok", {ok, err_crc, err_timeout}, 4);
    chk(last_prog_w == PROG_LOW_CYC, "R1 program low width", last_prog_w, PROG_LOW_CYC);
    chk(prog_pulses == 1, "R1 start while busy ignored", prog_pulses, 1);
    chk(accepted == 4, "R6 exactly byte_count taken", accepted, 4);
    chk(exp_q.size() == 0, "R3 every byte reached target", exp_q.size(), 0);
    chk(trail_cnt == TRAIL_CLKS && trail_bad == 0, "R7 dummy pulses with din high",
        trail_cnt, TRAIL_CLKS);
    chk(hi_bad == 0 && low_bad == 0 && din_bad == 0, "R4 clock phases and data hold",
        hi_bad + low_bad + din_bad, 0);
    chk(early == 0, "R2 nothing sent before init high", early, 0);

    // slow source stalls the clock
    run_prep(3);
    pulse_start();
    feed(3, 60, 1);
    wait_idle(2000);
    chk(ok, "R5 stalled load still completes", ok, 1);
    chk(rx_bits == 3 * 8 + TRAIL_CLKS, "R5 pulse count with stalls", rx_bits, 3 * 8 + TRAIL_CLKS);

    // zero-length image
    run_prep(0);
    pulse_start();
    fork feed(1, 0, 2); join_none
    wait_idle(2000);
    wait fork;
    chk(accepted == 0 && ok, "R6 zero count takes no byte", accepted, 0);
    chk(trail_cnt == TRAIL_CLKS, "R7 zero count still sends dummies", trail_cnt, TRAIL_CLKS);

    // init drops mid-load
    run_prep(4); fail_bit = 13;
    pulse_start();
    feed(4, 2, 3);
    wait_idle(2000);
    chk(err_crc && !ok && !err_timeout, "R8 init low flags image error",
        {err_crc, ok, err_timeout}, 4);
    t = rx_bits;
    repeat (50) @(negedge clk);
    chk(rx_bits == t && !tgt_cclk && !in_ready, "R8 clock stays stopped", rx_bits, t);

    // init drop on the last data bit collides with the move to dummies
    run_prep(2); fail_bit = 16;
    pulse_start();
    feed(2, 2, 4);
    wait_idle(2000);
    chk(err_crc && !ok, "R8 error wins over completion", {err_crc, ok}, 2);
    chk(trail_cnt == 0, "R8 no dummy pulse after error", trail_cnt, 0);
    fail_bit = 0;

    // init never rises
    run_prep(2); init_stuck = 1;
    pulse_start();
    t = 0;
    while (busy && t < 2000) begin t++; @(negedge clk); end
    chk(t == PROG_LOW_CYC + TIMEOUT_CYC, "R2 init timeout length", t, PROG_LOW_CYC + TIMEOUT_CYC);
    chk(err_timeout && !err_crc && !ok, "R2 init timeout flag", {err_timeout, err_crc, ok}, 4);
    chk(rx_bits == 0 && early == 0, "R2 no pulses without init", rx_bits + early, 0);
    init_stuck = 0;

    // restart from error, done never rises
    run_prep(1); done_en = 0;
    pulse_start();
    repeat (2) @(negedge clk);
    chk(!err_crc && !err_timeout && busy, "R10 start clears flags", {err_crc, err_timeout}, 0);
    feed(1, 2, 5);
    wait_idle(3000);
    chk(err_timeout && !ok && !err_crc, "R9 done timeout", {err_timeout, ok, err_crc}, 4);
    done_en = 1;

    // clean load started from the error state
    run_prep(2);
    pulse_start();
    feed(2, 1, 6);
    wait_idle(2000);
    chk(ok && !err_timeout && exp_q.size() == 0, "R1 start honoured in error state", ok, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule